// File: doc/BRIEF.md
# Command Mailbox with Handshake Sequencing

This block is a 16-bit mailbox between a bus master and an on-board command server. Every command word, input operand and reply word passes through one data register. Two status flags tell the master when it may act. The write-ready flag says a new word may be written. The reply-ready flag says a reply word is waiting to be read. Each flag drops on the master's own access. Only the server side raises it again: the write-ready flag when the server consumes the word, and the reply-ready flag when the server posts a reply.

A small sequencer checks the order of transactions. The top two bits of every opcode give its class, and the class decides what comes next: another opcode, one input operand, or one reply read. An access that is out of order, or that finds its flag low, is dropped and sets a sticky error flag. The error flag shows in the status word and clears when the status word is read. The server takes written words through a valid/ready port, and each word carries a tag that says whether it is an opcode or an operand. Replies come in on a strobed input.

Top module: `cmd_mailbox`

## Requirements
- R1: After the synchronous reset, `bus_status` reads 16'h0001 (write-ready 1, reply-ready 0, error 0), `srv_valid` is 0, `bus_rdata` is 0 and the sequencer expects an opcode.
- R2: An accepted master write appears on `srv_word` with `srv_valid` high at the next clock edge. `srv_tag` is 1 for an opcode and 0 for an operand. The word and tag stay unchanged while `srv_ready` is low.
- R3: Write-ready (status bit 0) clears on an accepted write. It sets again only on the cycle after `srv_valid && srv_ready`.
- R4: Reply-ready (status bit 1) sets on the cycle after `rep_valid` while a reply is awaited, and at that point `bus_rdata` shows `rep_data`. A read with reply-ready at 1 clears reply-ready, and the sequencer then expects an opcode again.
- R5: The opcode class is bits [15:14]: 00 takes no operand, 01 takes one input operand, 10 produces one reply, and 11 is treated as 00. Only after a class-01 opcode is the next accepted write tagged as an operand. After that operand, the next write is an opcode.
- R6: A write while write-ready is 0 is dropped (nothing reaches the server) and sets the error flag.
- R7: A read while reply-ready is 0 leaves `bus_rdata` and the sequencer unchanged and sets the error flag.
- R8: A write issued after a class-10 opcode, before its reply has been read, is dropped even when write-ready is 1, and it sets the error flag.
- R9: A `rep_valid` pulse while no reply is awaited, or while reply-ready is already 1, is ignored: `bus_rdata` and reply-ready keep their values.
- R10: Status bit 0 is write-ready, bit 1 is reply-ready and bit 2 is the error flag; all other bits read 0. A `bus_st_rd` pulse clears the error flag at the next edge. If a violation falls in the same cycle as that pulse, the flag stays 1.
- R11: A reset in the middle of a sequence returns the sequencer to expect-opcode, so the next write is tagged as an opcode even if it followed a class-01 opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Master write strobe for the data register |
| bus_wdata | input | 16 | Master write word |
| bus_rd | input | 1 | Master read strobe for the data register |
| bus_rdata | output | 16 | Reply word held for the master |
| bus_st_rd | input | 1 | Master status read strobe (clears the error flag) |
| bus_status | output | 16 | Status: bit0 write-ready, bit1 reply-ready, bit2 error |
| srv_valid | output | 1 | Word available to the server |
| srv_ready | input | 1 | Server consumes the word |
| srv_word | output | 16 | Word passed to the server |
| srv_tag | output | 1 | 1 = opcode, 0 = operand |
| rep_valid | input | 1 | Server posts a reply |
| rep_data | input | 16 | Reply word |

## Verification
Two actions can land on the error flag in the same cycle: the clear caused by a status read and the set caused by a protocol violation. The bench holds `srv_ready` low so that write-ready stays 0. It then raises an illegal write and a status read together, and it expects the status word afterwards to show the error bit still set. A plain status read after that must then clear the bit. The queue of words sent to the server is checked at the same time, so a dropped word that leaked through would show up as an unexpected item.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    SQ_OPC  = 2'd0,
    SQ_OPND = 2'd1,
    SQ_RPL  = 2'd2
  } sq_t;

  typedef enum logic [1:0] {
    CL_NONE = 2'd0,
    CL_IN   = 2'd1,
    CL_OUT  = 2'd2,
    CL_RSV  = 2'd3
  } cls_t;

  localparam int ST_WOK = 0;
  localparam int ST_ROK = 1;
  localparam int ST_ERR = 2;

  function automatic sq_t after_opcode(cls_t c);
    case (c)
      CL_IN:   return SQ_OPND;
      CL_OUT:  return SQ_RPL;
      default: return SQ_OPC;
    endcase
  endfunction

endpackage

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int CLS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [CLS_W-1:0] cls,
  input  logic             wok,
  input  logic             rok,
  output logic             acc_wr,
  output logic             wr_is_opc,
  output logic             acc_rd,
  output logic             viol,
  output logic             awaiting
);

  sq_t state, state_nx;

  assign awaiting  = (state == SQ_RPL);
  assign acc_wr    = bus_wr && wok && !awaiting;
  assign acc_rd    = bus_rd && rok;
  assign wr_is_opc = (state == SQ_OPC);
  assign viol      = (bus_wr && !acc_wr) || (bus_rd && !acc_rd);

  always_comb begin
    state_nx = state;
    if (acc_wr) begin
      if (state == SQ_OPC) state_nx = after_opcode(cls_t'(cls[1:0]));
      else                 state_nx = SQ_OPC;
    end else if (acc_rd) begin
      state_nx = SQ_OPC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SQ_OPC;
    else     state <= state_nx;
  end

endmodule

// File: rtl/mbx_flags.sv
module mbx_flags (
  input  logic clk,
  input  logic rst,
  input  logic acc_wr,
  input  logic consume,
  input  logic rep_take,
  input  logic acc_rd,
  input  logic viol,
  input  logic st_rd,
  output logic wok,
  output logic rok,
  output logic err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wok <= 1'b1;
      rok <= 1'b0;
      err <= 1'b0;
    end else begin
      if (acc_wr)       wok <= 1'b0;
      else if (consume) wok <= 1'b1;

      if (rep_take)    rok <= 1'b1;
      else if (acc_rd) rok <= 1'b0;

      if (viol)       err <= 1'b1;
      else if (st_rd) err <= 1'b0;
    end
  end

endmodule

// File: rtl/mbx_hold.sv
module mbx_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_wr,
  input  logic          wr_is_opc,
  input  logic [DW-1:0] wdata,
  input  logic          consume,
  input  logic          rep_take,
  input  logic [DW-1:0] rep_data,
  output logic          srv_valid,
  output logic [DW-1:0] srv_word,
  output logic          srv_tag,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      srv_valid <= 1'b0;
      srv_word  <= '0;
      srv_tag   <= 1'b0;
      rdata     <= '0;
    end else begin
      if (acc_wr) begin
        srv_valid <= 1'b1;
        srv_word  <= wdata;
        srv_tag   <= wr_is_opc;
      end else if (consume) begin
        srv_valid <= 1'b0;
      end
      if (rep_take) rdata <= rep_data;
    end
  end

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CLS_W = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic          bus_st_rd,
  output logic [DW-1:0] bus_status,
  output logic          srv_valid,
  input  logic          srv_ready,
  output logic [DW-1:0] srv_word,
  output logic          srv_tag,
  input  logic          rep_valid,
  input  logic [DW-1:0] rep_data
);

  localparam int CLS_LSB = DW - CLS_W;

  logic acc_wr, wr_is_opc, acc_rd, viol, awaiting;
  logic wok, rok, err;
  logic consume, rep_take;

  assign consume  = srv_valid && srv_ready;
  assign rep_take = rep_valid && awaiting && !rok;

  mbx_seq #(.CLS_W(CLS_W)) u_seq (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .cls(bus_wdata[DW-1:CLS_LSB]), .wok(wok), .rok(rok),
    .acc_wr(acc_wr), .wr_is_opc(wr_is_opc), .acc_rd(acc_rd),
    .viol(viol), .awaiting(awaiting)
  );

  mbx_flags u_flags (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .consume(consume),
    .rep_take(rep_take), .acc_rd(acc_rd), .viol(viol), .st_rd(bus_st_rd),
    .wok(wok), .rok(rok), .err(err)
  );

  mbx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .wr_is_opc(wr_is_opc),
    .wdata(bus_wdata), .consume(consume), .rep_take(rep_take),
    .rep_data(rep_data), .srv_valid(srv_valid), .srv_word(srv_word),
    .srv_tag(srv_tag), .rdata(bus_rdata)
  );

  always_comb begin
    bus_status         = '0;
    bus_status[ST_WOK] = wok;
    bus_status[ST_ROK] = rok;
    bus_status[ST_ERR] = err;
  end

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          bus_st_rd,
  input logic [DW-1:0] bus_status,
  input logic [DW-1:0] bus_rdata,
  input logic          srv_valid,
  input logic          srv_ready,
  input logic [DW-1:0] srv_word,
  input logic          srv_tag,
  input logic          rep_valid,
  input logic          awaiting
);

  logic wok, rok, err;
  assign wok = bus_status[0];
  assign rok = bus_status[1];
  assign err = bus_status[2];

  AST_WOK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && wok && !awaiting) |=> (!wok && srv_valid)); // R3
  AST_WOK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wok && !(srv_valid && srv_ready)) |=> !wok); // R3
  AST_ROK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rok && !rep_valid) |=> !rok); // R4
  AST_ROK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && rok) |=> !rok); // R4
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !wok) |=> err); // R6
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !rok) |=> (err && $stable(bus_rdata))); // R7
  AST_WR_IN_REPLY: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && awaiting) |=> err); // R8
  AST_RDATA_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(rep_valid && awaiting && !rok) |=> $stable(bus_rdata)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !bus_st_rd) |=> err); // R10
  AST_SRV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (srv_valid && !srv_ready) |=> (srv_valid && $stable(srv_word) && $stable(srv_tag))); // R2

endmodule

bind cmd_mailbox mbx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_st_rd(bus_st_rd), .bus_status(bus_status), .bus_rdata(bus_rdata),
  .srv_valid(srv_valid), .srv_ready(srv_ready), .srv_word(srv_word),
  .srv_tag(srv_tag), .rep_valid(rep_valid), .awaiting(awaiting)
);

// File: tb/cmd_mailbox_tb.sv
`timescale 1ns/1ps
module cmd_mailbox_tb;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_st_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata, bus_status;
  logic          srv_valid, srv_ready = 1'b1, srv_tag;
  logic [DW-1:0] srv_word;
  logic          rep_valid = 1'b0;
  logic [DW-1:0] rep_data = '0;

  int n_chk = 0, n_bad = 0;
  logic [DW:0] expq[$];

  always #5 clk = ~clk;

  cmd_mailbox #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_st_rd(bus_st_rd),
    .bus_status(bus_status), .srv_valid(srv_valid), .srv_ready(srv_ready),
    .srv_word(srv_word), .srv_tag(srv_tag), .rep_valid(rep_valid),
    .rep_data(rep_data)
  );

  task automatic chk(input string req, input logic [DW:0] got, input logic [DW:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // monitor: pops expected server words as they are consumed
  always @(negedge clk) begin
    if (!rst && srv_valid && srv_ready) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R2: got %h expected none", {srv_tag, srv_word});
      end else begin
        logic [DW:0] e;
        e = expq.pop_front();
        if ({srv_tag, srv_word} !== e) begin
          n_bad++;
          $display("FAIL R2/R5: got %h expected %h", {srv_tag, srv_word}, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d, input logic tag, input logic legal);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d;
    if (legal) expq.push_back({tag, d});
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic st_rd();
    @(negedge clk);
    bus_st_rd = 1'b1;
    @(negedge clk);
    bus_st_rd = 1'b0;
  endtask

  task automatic reply(input logic [DW-1:0] d);
    @(negedge clk);
    rep_valid = 1'b1; rep_data = d;
    @(negedge clk);
    rep_valid = 1'b0;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #1 srv_ready = v;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 status", {1'b0, bus_status}, 17'h00001);
    chk("R1 srv_valid", {16'h0, srv_valid}, 17'h0);
    chk("R1 rdata", {1'b0, bus_rdata}, 17'h0);

    // class decode and tagging
    wr(16'h0012, 1'b1, 1'b1);
    chk("R3 wok low after write", {1'b0, bus_status}, 17'h00000);
    idle(1);
    chk("R3 wok back after consume", {1'b0, bus_status}, 17'h00001);
    wr(16'h4A05, 1'b1, 1'b1);
    wr(16'h00FF, 1'b0, 1'b1);   // R5 operand
    wr(16'h1234, 1'b1, 1'b1);   // R5 back to opcode
    wr(16'hC001, 1'b1, 1'b1);   // R5 class 11 acts as none
    wr(16'h0033, 1'b1, 1'b1);
    idle(1);

    // reply path
    wr(16'h8003, 1'b1, 1'b1);
    idle(1);
    chk("R4 no reply yet", {1'b0, bus_status}, 17'h00001);
    rd(d);
    chk("R7 err after early read", {1'b0, bus_status}, 17'h00005);
    chk("R7 rdata unchanged", {1'b0, bus_rdata}, 17'h0);
    st_rd();
    chk("R10 err cleared", {1'b0, bus_status}, 17'h00001);
    wr(16'h0044, 1'b1, 1'b0);
    chk("R8 write in reply wait dropped", {16'h0, srv_valid}, 17'h0);
    chk("R8 err set", {1'b0, bus_status}, 17'h00005);
    st_rd();
    reply(16'hBEEF);
    chk("R4 rok set", {1'b0, bus_status}, 17'h00003);
    chk("R4 rdata", {1'b0, bus_rdata}, {1'b0, 16'hBEEF});
    reply(16'h1111);
    chk("R9 second reply ignored", {1'b0, bus_rdata}, {1'b0, 16'hBEEF});
    rd(d);
    chk("R4 read value", {1'b0, d}, {1'b0, 16'hBEEF});
    chk("R4 rok cleared", {1'b0, bus_status}, 17'h00001);
    reply(16'h2222);
    chk("R9 unsolicited reply ignored", {1'b0, bus_rdata}, {1'b0, 16'hBEEF});
    chk("R9 rok stays 0", {1'b0, bus_status}, 17'h00001);
    wr(16'h0021, 1'b1, 1'b1);   // R4 sequencer back to opcode
    idle(1);

    // write while server stalls
    set_ready(1'b0);
    wr(16'h0007, 1'b1, 1'b1);
    wr(16'h0008, 1'b1, 1'b0);
    chk("R6 err set", {1'b0, bus_status}, 17'h00004);
    chk("R2 word held", {srv_tag, srv_word}, {1'b1, 16'h0007});
    chk("R2 valid held", {16'h0, srv_valid}, 17'h1);
    set_ready(1'b1);
    idle(2);
    chk("R3 wok after late consume", {1'b0, bus_status}, 17'h00005);
    st_rd();
    chk("R10 cleared", {1'b0, bus_status}, 17'h00001);

    // same-cycle violation and status read
    set_ready(1'b0);
    wr(16'h0009, 1'b1, 1'b1);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 16'h000A; bus_st_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_st_rd = 1'b0;
    chk("R10 set wins over clear", {1'b0, bus_status}, 17'h00004);
    set_ready(1'b1);
    idle(2);
    st_rd();
    chk("R10 status after clear", {1'b0, bus_status}, 17'h00001);

    // reset mid-sequence
    wr(16'h4000, 1'b1, 1'b1);
    idle(1);
    rd(d);
    chk("R7 err before reset", {1'b0, bus_status}, 17'h00005);
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    chk("R11 status after reset", {1'b0, bus_status}, 17'h00001);
    wr(16'h0055, 1'b1, 1'b1);   // R11 tagged as opcode
    idle(2);
    chk("R2 queue drained", {1'b0, 16'(expq.size())}, 17'h0);
    finish_run();
  end

endmodule